// File: doc/BRIEF.md
# BCD Real-Time Clock with Update Freeze

This block is a calendar clock that keeps time in packed BCD. It holds eight running counters: seconds, minutes, hours, day of month, day of week, month, two-digit year and two-digit century. A single-cycle `tick_i` strobe, once per second, advances them by calendar rules. Software reaches every register by a plain byte offset on a simple register port. There is no index-then-data indirection. Reads return data one cycle after the request.

Software sees snapshot copies of the counters, not the counters themselves. Each tick reloads the snapshot, unless the freeze bit in the control register is set. While the freeze bit is set, software can read a time that stays consistent, while the counters keep running underneath. Software can also write new field values into the snapshot; when the freeze bit is cleared, exactly the fields that were written are loaded into the counters. A date alarm compares seconds, minutes, hours and day of month with the running time after each tick and latches a flag. Reading the flag clears it, and the flag drives an interrupt output when enabled.

The register port has no back-pressure. It is always ready and accepts one access per cycle. `bus_rvalid_o` marks the cycle that carries read data, and the requester must take the data in that cycle.

Top module: `rtc_top`

## Requirements
- R1: An access with `bus_sel_i`=1 uses `bus_addr_i` directly as the register offset. A read (`bus_wr_i`=0) produces `bus_rvalid_o`=1 and its data on `bus_rdata_o` in the following cycle. Map: 0 seconds, 1 minutes, 2 hours, 3 day of month, 4 day of week, 5 month, 6 year, 7 century, 8..11 alarm seconds/minutes/hours/day of month, 12 enables, 13 flags, 14 control, 15 reads 0.
- R2: All time and alarm fields are packed BCD (high nibble tens). After reset the time reads 20 00-01-01 00:00:00 with day of week 01, and the alarm, enables, flags and control registers read 00.
- R3: A tick advances the counters at its clock edge. When the freeze bit was 0 at that edge, the visible copies are reloaded from the counters at the following edge.
- R4: Rollover: seconds and minutes wrap 59 to 00, hours 23 to 00, day of week 07 to 01, and day of month wraps to 01 after the month length. That length is 30 for months 04, 06, 09 and 11, 31 for the other months except February, and for February 29 in a leap year and 28 otherwise. A year is a leap year when it is divisible by 4 and is not divisible by 100, except that a year divisible by 400 is a leap year. Month wraps 12 to 01, and year wraps 99 to 00 while incrementing the century.
- R5: While control bit 3 (freeze) is 1, the visible time registers do not reload, but the counters keep advancing on every tick.
- R6: A write to offsets 0..7 while freeze is 1 updates that visible register and marks it. A control write that clears bit 3 while freeze is 1 loads every marked field into its counter and drops the marks. Unmarked fields keep their running value.
- R7: A write to offsets 0..7 while freeze is 0 has no effect.
- R8: When a tick lands with freeze 0 and freeze is set at the next edge, the reload started by that tick still completes.
- R9: At the edge after a tick, if the alarm seconds, minutes, hours and day of month all equal the counters, flags bit 0 is set.
- R10: A read of offset 13 returns the flag and clears it. If the flag is being set in the same cycle, the set wins: the read returns 0 and the flag stays 1.
- R11: `irq_o` is 1 exactly while flags bit 0 and enables bit 0 are both 1. Enables bit 1 is stored and readable, the other enables bits read 0, and writes to offset 13 are ignored.
- R12: The control register stores and returns all eight bits written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-second strobe, one cycle wide |
| bus_sel_i | input | 1 | Register access request this cycle |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 4 | Register offset |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, valid while bus_rvalid_o is 1 |
| bus_rvalid_o | output | 1 | Read data valid, one cycle after a read request |
| irq_o | output | 1 | Alarm interrupt |

## Verification
The alarm flag can be set and cleared in the same cycle. This happens when a read of the flags register lands on the edge right after the tick that makes the time match the alarm. The bench provokes it by issuing that read immediately after a matching tick. The read must return 0, and a second read must return 1. The same edge-by-edge reference model also judges the second overlap: a freeze that is raised in the cycle after a tick, while the reload is still pending.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int DATA_W   = 8;
  localparam int ADDR_W   = 4;
  localparam int FIELD_N  = 8;
  localparam int ALARM_N  = 4;
  localparam int FIELD_AW = $clog2(FIELD_N);
  localparam int ALARM_AW = $clog2(ALARM_N);

  localparam int FS  = 0;
  localparam int FM  = 1;
  localparam int FH  = 2;
  localparam int FD  = 3;
  localparam int FW  = 4;
  localparam int FMO = 5;
  localparam int FY  = 6;
  localparam int FC  = 7;

  localparam logic [ADDR_W-1:0] ADR_EN  = ADDR_W'(12);
  localparam logic [ADDR_W-1:0] ADR_FLG = ADDR_W'(13);
  localparam logic [ADDR_W-1:0] ADR_CTL = ADDR_W'(14);

  localparam int INH_BIT = 3;
  localparam int AIE_BIT = 0;

  typedef logic [DATA_W-1:0] bcd_t;

  function automatic bcd_t bcd_inc(bcd_t v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [6:0] bcd_to_bin(bcd_t v);
    return ({3'b0, v[7:4]} * 7'd10) + {3'b0, v[3:0]};
  endfunction

  function automatic bcd_t field_init(int idx);
    case (idx)
      FD, FW, FMO: return 8'h01;
      FC:          return 8'h20;
      default:     return 8'h00;
    endcase
  endfunction

  function automatic bcd_t month_days(bcd_t mo, bcd_t yr, bcd_t ce);
    logic [6:0] yb;
    logic [6:0] cb;
    logic       leap;
    yb   = bcd_to_bin(yr);
    cb   = bcd_to_bin(ce);
    leap = (yb == 7'd0) ? (cb[1:0] == 2'd0) : (yb[1:0] == 2'd0);
    case (mo)
      8'h02:                      return leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick_i,
  input  logic               commit_i,
  input  logic [FIELD_N-1:0] commit_mask_i,
  input  bcd_t               commit_val_i [FIELD_N],
  output bcd_t               cnt_o [FIELD_N]
);
  bcd_t nxt [FIELD_N];
  bcd_t mlen;
  logic c_sec, c_min, c_hr, c_day, c_mon, c_yr;

  // carry chain across the calendar fields
  always_comb begin
    for (int i = 0; i < FIELD_N; i++) nxt[i] = cnt_o[i];
    mlen  = month_days(cnt_o[FMO], cnt_o[FY], cnt_o[FC]);
    c_sec = (cnt_o[FS] == 8'h59);
    c_min = c_sec && (cnt_o[FM] == 8'h59);
    c_hr  = c_min && (cnt_o[FH] == 8'h23);
    c_day = c_hr  && (cnt_o[FD] == mlen);
    c_mon = c_day && (cnt_o[FMO] == 8'h12);
    c_yr  = c_mon && (cnt_o[FY] == 8'h99);
    nxt[FS] = c_sec ? 8'h00 : bcd_inc(cnt_o[FS]);
    if (c_sec) nxt[FM]  = (cnt_o[FM] == 8'h59) ? 8'h00 : bcd_inc(cnt_o[FM]);
    if (c_min) nxt[FH]  = (cnt_o[FH] == 8'h23) ? 8'h00 : bcd_inc(cnt_o[FH]);
    if (c_hr) begin
      nxt[FW] = (cnt_o[FW] == 8'h07) ? 8'h01 : bcd_inc(cnt_o[FW]);
      nxt[FD] = (cnt_o[FD] == mlen) ? 8'h01 : bcd_inc(cnt_o[FD]);
    end
    if (c_day) nxt[FMO] = (cnt_o[FMO] == 8'h12) ? 8'h01 : bcd_inc(cnt_o[FMO]);
    if (c_mon) nxt[FY]  = (cnt_o[FY] == 8'h99) ? 8'h00 : bcd_inc(cnt_o[FY]);
    if (c_yr)  nxt[FC]  = (cnt_o[FC] == 8'h99) ? 8'h00 : bcd_inc(cnt_o[FC]);
  end

  for (genvar g = 0; g < FIELD_N; g++) begin : g_fld
    bcd_t q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           q <= field_init(g);
      else if (commit_i && commit_mask_i[g]) q <= commit_val_i[g];
      else if (tick_i)                      q <= nxt[g];
    end
    assign cnt_o[g] = q;
  end
endmodule

// File: rtl/rtc_shadow.sv
module rtc_shadow
  import rtc_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                refresh_i,
  input  bcd_t                cnt_i [FIELD_N],
  input  logic                wr_i,
  input  logic [FIELD_AW-1:0] wr_idx_i,
  input  bcd_t                wr_data_i,
  input  logic                clr_dirty_i,
  output bcd_t                vis_o [FIELD_N],
  output logic [FIELD_N-1:0]  dirty_o
);
  for (genvar g = 0; g < FIELD_N; g++) begin : g_vis
    bcd_t q;
    logic d;
    logic hit;
    assign hit = wr_i && (wr_idx_i == FIELD_AW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= field_init(g);
        d <= 1'b0;
      end else begin
        if (hit)            q <= wr_data_i;
        else if (refresh_i) q <= cnt_i[g];
        if (hit)              d <= 1'b1;
        else if (clr_dirty_i) d <= 1'b0;
      end
    end
    assign vis_o[g]   = q;
    assign dirty_o[g] = d;
  end
endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm
  import rtc_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                eval_i,
  input  bcd_t                now_i [ALARM_N],
  input  logic                wr_i,
  input  logic [ALARM_AW-1:0] wr_idx_i,
  input  bcd_t                wr_data_i,
  input  logic                rd_clr_i,
  output bcd_t                alm_o [ALARM_N],
  output logic                flag_o
);
  logic [ALARM_N-1:0] eq;

  for (genvar g = 0; g < ALARM_N; g++) begin : g_alm
    bcd_t q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                    q <= '0;
      else if (wr_i && (wr_idx_i == ALARM_AW'(g)))   q <= wr_data_i;
    end
    assign alm_o[g] = q;
    assign eq[g]    = (q == now_i[g]);
  end

  // a new match outranks a clearing read in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                flag_o <= 1'b0;
    else if (eval_i && (&eq))  flag_o <= 1'b1;
    else if (rd_clr_i)         flag_o <= 1'b0;
  end
endmodule

// File: rtl/rtc_top.sv
module rtc_top
  import rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              bus_sel_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              bus_rvalid_o,
  output logic              irq_o
);
  logic [DATA_W-1:0] ctl_q;
  logic [1:0]        en_q;
  logic              pend_q;
  logic              eval_q;
  bcd_t              cnt  [FIELD_N];
  bcd_t              vis  [FIELD_N];
  bcd_t              now  [ALARM_N];
  bcd_t              alm  [ALARM_N];
  logic [FIELD_N-1:0] dirty;
  logic              alm_flag;
  logic              rd_req, wr_req, inh, time_wr, alm_wr, commit, flag_rd;
  bcd_t              rmux;

  assign rd_req  = bus_sel_i & ~bus_wr_i;
  assign wr_req  = bus_sel_i & bus_wr_i;
  assign inh     = ctl_q[INH_BIT];
  assign time_wr = wr_req & ~bus_addr_i[ADDR_W-1] & inh;
  assign alm_wr  = wr_req & (bus_addr_i[ADDR_W-1:ADDR_W-2] == 2'b10);
  assign commit  = wr_req & (bus_addr_i == ADR_CTL) & inh & ~bus_wdata_i[INH_BIT];
  assign flag_rd = rd_req & (bus_addr_i == ADR_FLG);

  for (genvar g = 0; g < ALARM_N; g++) begin : g_now
    assign now[g] = cnt[g];
  end

  rtc_calendar u_cal (
    .clk           (clk),
    .rst_n         (rst_n),
    .tick_i        (tick_i),
    .commit_i      (commit),
    .commit_mask_i (dirty),
    .commit_val_i  (vis),
    .cnt_o         (cnt)
  );

  rtc_shadow u_shd (
    .clk         (clk),
    .rst_n       (rst_n),
    .refresh_i   (pend_q),
    .cnt_i       (cnt),
    .wr_i        (time_wr),
    .wr_idx_i    (bus_addr_i[FIELD_AW-1:0]),
    .wr_data_i   (bus_wdata_i),
    .clr_dirty_i (commit),
    .vis_o       (vis),
    .dirty_o     (dirty)
  );

  rtc_alarm u_alm (
    .clk       (clk),
    .rst_n     (rst_n),
    .eval_i    (eval_q),
    .now_i     (now),
    .wr_i      (alm_wr),
    .wr_idx_i  (bus_addr_i[ALARM_AW-1:0]),
    .wr_data_i (bus_wdata_i),
    .rd_clr_i  (flag_rd),
    .alm_o     (alm),
    .flag_o    (alm_flag)
  );

  always_comb begin
    rmux = '0;
    if (!bus_addr_i[ADDR_W-1]) begin
      rmux = vis[bus_addr_i[FIELD_AW-1:0]];
    end else if (bus_addr_i[ADDR_W-2] == 1'b0) begin
      rmux = alm[bus_addr_i[ALARM_AW-1:0]];
    end else begin
      case (bus_addr_i)
        ADR_EN:  rmux = {{(DATA_W-2){1'b0}}, en_q};
        ADR_FLG: rmux = {{(DATA_W-1){1'b0}}, alm_flag};
        ADR_CTL: rmux = ctl_q;
        default: rmux = '0;
      endcase
    end
  end

  // reload is armed by a tick seen while unfrozen and lands one edge later
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q        <= '0;
      en_q         <= '0;
      pend_q       <= 1'b0;
      eval_q       <= 1'b0;
      bus_rvalid_o <= 1'b0;
      bus_rdata_o  <= '0;
    end else begin
      if (wr_req && (bus_addr_i == ADR_CTL)) ctl_q <= bus_wdata_i;
      if (wr_req && (bus_addr_i == ADR_EN))  en_q  <= bus_wdata_i[1:0];
      pend_q       <= tick_i & ~inh;
      eval_q       <= tick_i;
      bus_rvalid_o <= rd_req;
      if (rd_req) bus_rdata_o <= rmux;
    end
  end

  assign irq_o = alm_flag & en_q[AIE_BIT];
endmodule

// File: rtl/rtc_chk.sv
module rtc_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick_i,
  input logic       sel,
  input logic       wr,
  input logic [3:0] addr,
  input logic       wbit3,
  input logic       rvalid,
  input logic       irq,
  input logic       inh,
  input logic       pend,
  input logic       eval,
  input logic       flag,
  input logic [7:0] vis_sec,
  input logic [7:0] cnt_sec,
  input logic       dirty_sec
);
  // R1
  rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && !wr) |=> rvalid);

  // R2
  sec_bcd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_sec[3:0] <= 4'd9) && (cnt_sec < 8'h60));

  // R3
  reload_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> $past(tick_i));

  // R5
  frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inh && !pend && !(sel && wr && addr == 4'd0)) |=> $stable(vis_sec));

  // R6
  commit_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && wr && addr == 4'd14 && inh && !wbit3 && dirty_sec) |=> (cnt_sec == $past(vis_sec)));

  // R8
  reload_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !(sel && wr && addr == 4'd0)) |=> (vis_sec == $past(cnt_sec)));

  // R10
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && !wr && addr == 4'd13 && !eval) |=> !flag);

  // R11
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(eval) || $past(sel && wr && addr == 4'd12)));
endmodule

bind rtc_top rtc_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick_i    (tick_i),
  .sel       (bus_sel_i),
  .wr        (bus_wr_i),
  .addr      (bus_addr_i),
  .wbit3     (bus_wdata_i[3]),
  .rvalid    (bus_rvalid_o),
  .irq       (irq_o),
  .inh       (ctl_q[3]),
  .pend      (pend_q),
  .eval      (eval_q),
  .flag      (alm_flag),
  .vis_sec   (vis[0]),
  .cnt_sec   (cnt[0]),
  .dirty_sec (dirty[0])
);

// File: tb/rtc_top_tb_top.sv
`timescale 1ns/1ps
module rtc_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick_i;
  logic       bus_sel_i;
  logic       bus_wr_i;
  logic [3:0] bus_addr_i;
  logic [7:0] bus_wdata_i;
  logic [7:0] bus_rdata_o;
  logic       bus_rvalid_o;
  logic       irq_o;

  always #2 clk = ~clk;

  rtc_top dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick_i       (tick_i),
    .bus_sel_i    (bus_sel_i),
    .bus_wr_i     (bus_wr_i),
    .bus_addr_i   (bus_addr_i),
    .bus_wdata_i  (bus_wdata_i),
    .bus_rdata_o  (bus_rdata_o),
    .bus_rvalid_o (bus_rvalid_o),
    .irq_o        (irq_o)
  );

  int    n_chk  = 0;
  int    n_fail = 0;
  bit    run    = 0;
  string cur_tag = "R2";
  string m_rtag  = "R2";

  // behavioural reference state (binary time, raw alarm bytes)
  int m_cnt [8];
  int m_vis [8];
  bit m_dirty [8];
  int m_alm [4];
  int m_en, m_ctl, m_rdata;
  bit m_flag, m_pend, m_eval, m_rvalid;
  int oc [8];
  int ov [8];
  bit inh, rdq, wrq, nf;
  int ad, wd;

  function automatic int b2d(int v); return (v / 10) * 16 + (v % 10); endfunction
  function automatic int d2b(int v); return (v / 16) * 10 + (v % 16); endfunction

  function automatic int mdays(int mo, int yr, int ce);
    int full = ce * 100 + yr;
    if (mo == 2) return ((full % 4 == 0) && ((full % 100 != 0) || (full % 400 == 0))) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  task automatic m_advance();
    int ml = mdays(m_cnt[5], m_cnt[6], m_cnt[7]);
    m_cnt[0]++;
    if (m_cnt[0] == 60) begin
      m_cnt[0] = 0; m_cnt[1]++;
      if (m_cnt[1] == 60) begin
        m_cnt[1] = 0; m_cnt[2]++;
        if (m_cnt[2] == 24) begin
          m_cnt[2] = 0;
          m_cnt[4] = (m_cnt[4] == 7) ? 1 : m_cnt[4] + 1;
          m_cnt[3]++;
          if (m_cnt[3] > ml) begin
            m_cnt[3] = 1; m_cnt[5]++;
            if (m_cnt[5] == 13) begin
              m_cnt[5] = 1; m_cnt[6]++;
              if (m_cnt[6] == 100) begin
                m_cnt[6] = 0; m_cnt[7] = (m_cnt[7] + 1) % 100;
              end
            end
          end
        end
      end
    end
  endtask

  function automatic int m_reg(int a);
    if (a < 8)  return b2d(m_vis[a]);
    if (a < 12) return m_alm[a - 8];
    if (a == 12) return m_en;
    if (a == 13) return int'(m_flag);
    if (a == 14) return m_ctl;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = '{0, 0, 0, 1, 1, 1, 0, 20};
      m_vis = m_cnt;
      for (int i = 0; i < 8; i++) m_dirty[i] = 0;
      for (int i = 0; i < 4; i++) m_alm[i] = 0;
      m_en = 0; m_ctl = 0; m_flag = 0; m_pend = 0; m_eval = 0;
      m_rvalid = 0; m_rdata = 0;
    end else begin
      oc = m_cnt; ov = m_vis;
      inh = m_ctl[3];
      rdq = bus_sel_i && !bus_wr_i;
      wrq = bus_sel_i && bus_wr_i;
      ad  = int'(bus_addr_i);
      wd  = int'(bus_wdata_i);
      m_rvalid = rdq;
      if (rdq) begin
        m_rdata = m_reg(ad);
        m_rtag  = cur_tag;
      end
      nf = m_flag;
      if (m_eval && b2d(oc[0]) == m_alm[0] && b2d(oc[1]) == m_alm[1] &&
          b2d(oc[2]) == m_alm[2] && b2d(oc[3]) == m_alm[3]) nf = 1;
      else if (rdq && ad == 13) nf = 0;
      if (tick_i) m_advance();
      if (wrq && ad == 14 && inh && !bus_wdata_i[3]) begin
        for (int i = 0; i < 8; i++) if (m_dirty[i]) begin
          m_cnt[i] = ov[i]; m_dirty[i] = 0;
        end
      end
      if (m_pend) m_vis = oc;
      if (wrq && ad < 8 && inh) begin
        m_vis[ad] = d2b(wd); m_dirty[ad] = 1;
      end
      if (wrq && ad >= 8 && ad < 12) m_alm[ad - 8] = wd;
      if (wrq && ad == 12) m_en = wd & 3;
      if (wrq && ad == 14) m_ctl = wd;
      m_pend = tick_i && !inh;
      m_eval = tick_i;
      m_flag = nf;
    end
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (run && rst_n) begin
      chk(bus_rvalid_o == m_rvalid, "R1", int'(bus_rvalid_o), int'(m_rvalid));
      if (m_rvalid) chk(int'(bus_rdata_o) == m_rdata, m_rtag, int'(bus_rdata_o), m_rdata);
      // R11: interrupt level against flag and enable
      chk(irq_o == (m_flag && m_en[0]), "R11", int'(irq_o), int'(m_flag && m_en[0]));
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus(bit w, int a, int d);
    bus_sel_i = 1; bus_wr_i = w; bus_addr_i = 4'(a); bus_wdata_i = 8'(d);
    @(negedge clk);
    bus_sel_i = 0; bus_wr_i = 0;
  endtask

  task automatic rd(int a, string tag);
    cur_tag = tag;
    bus(0, a, 0);
  endtask

  task automatic tk();
    tick_i = 1;
    @(negedge clk);
    tick_i = 0;
  endtask

  task automatic tk_n(int n);
    repeat (n) begin tk(); idle(2); end
  endtask

  task automatic rd_all(string tag);
    for (int a = 0; a < 8; a++) rd(a, tag);
  endtask

  task automatic set_time(int ce, int yr, int mo, int md, int hr, int mi, int se);
    bus(1, 14, 8);
    bus(1, 7, ce); bus(1, 6, yr); bus(1, 5, mo); bus(1, 3, md);
    bus(1, 2, hr); bus(1, 1, mi); bus(1, 0, se);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 0; tick_i = 0; bus_sel_i = 0; bus_wr_i = 0; bus_addr_i = 0; bus_wdata_i = 0;
    repeat (3) @(negedge clk);
    rst_n = 1; run = 1;
    // R2 reset values, R1 full map
    for (int a = 0; a < 16; a++) rd(a, (a < 8) ? "R2" : "R1");
    // R3 ticks reach the visible copies
    tk_n(3); rd(0, "R3"); rd(1, "R3");
    // R7 time write while unfrozen
    bus(1, 0, 'h33); idle(1); rd(0, "R7");
    // R6 frozen write, tick, commit
    set_time('h19, 'h99, 'h12, 'h31, 'h23, 'h59, 'h58);
    tk_n(1); rd(0, "R6");
    bus(1, 14, 0); rd_all("R6");
    tk_n(1); rd_all("R6");
    // R4 full carry into century
    tk_n(1); rd_all("R4");
    // R4 leap and month lengths
    set_time('h20, 'h00, 'h02, 'h28, 'h23, 'h59, 'h59); bus(1, 14, 0); tk_n(1); rd_all("R4");
    set_time('h21, 'h00, 'h02, 'h28, 'h23, 'h59, 'h59); bus(1, 14, 0); tk_n(1); rd_all("R4");
    set_time('h20, 'h24, 'h02, 'h28, 'h23, 'h59, 'h59); bus(1, 14, 0); tk_n(1); rd_all("R4");
    set_time('h20, 'h25, 'h04, 'h30, 'h23, 'h59, 'h59); bus(1, 14, 0); tk_n(1); rd_all("R4");
    // R4 day of week wrap
    bus(1, 14, 8); bus(1, 4, 7); bus(1, 2, 'h23); bus(1, 1, 'h59); bus(1, 0, 'h59);
    bus(1, 14, 0); tk_n(1); rd(4, "R4"); rd(3, "R4");
    // R5 frozen copies, running counters
    bus(1, 14, 8); tk_n(3); rd(0, "R5"); rd(1, "R5");
    bus(1, 14, 0); tk_n(1); rd(0, "R5"); rd(1, "R5");
    // R8 freeze raised right after a tick
    tk(); bus(1, 14, 8); idle(1); tk_n(2); rd(0, "R8"); rd(1, "R8");
    bus(1, 14, 0); tk_n(1); rd(0, "R8");
    // R12 control byte
    bus(1, 14, 'h85); rd(14, "R12"); bus(1, 14, 0); rd(14, "R12");
    // R9 alarm match
    bus(1, 14, 8); bus(1, 0, 'h10); bus(1, 1, 'h20); bus(1, 2, 'h05); bus(1, 3, 'h03);
    bus(1, 8, 'h12); bus(1, 9, 'h20); bus(1, 10, 'h05); bus(1, 11, 'h03);
    bus(1, 12, 'hFF); bus(1, 14, 0);
    rd(12, "R11");
    tk_n(1); rd(13, "R9");
    tk_n(1); idle(3); rd(13, "R9"); rd(13, "R10");
    // R10 set and clearing read in the same cycle
    bus(1, 8, 'h14); tk_n(1);
    tk(); rd(13, "R10"); rd(13, "R10"); rd(13, "R10");
    // R11 enable masking and ignored flag write
    bus(1, 12, 2); bus(1, 8, 'h15); tk_n(1); idle(3);
    rd(12, "R11"); bus(1, 13, 0); rd(13, "R11"); rd(13, "R11");
    idle(3);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule